// File: doc/BRIEF.md
# Ring Interrupt Status and Enable Controller

This block gathers completion events from a set of DMA rings, one transmit ring and one receive ring per hop, and turns them into interrupt pulses on a small number of vector lines. Each hop can raise three kinds of event, each on its own input strobe: transmit done, receive done and receive overflow. Each event sets a pending bit that host software can read over a simple 32-bit register port. A read of a status word returns its pending bits and clears them in the same access.

Software chooses which rings may interrupt with a bank of enable bits. It steers each ring to a vector through a packed table of small vector fields, and it bounds how often each vector can fire with a per-vector minimum interval counted in 256 ns units. A control bit selects auto-clear. In that mode a ring's done bit is dropped when the vector it feeds fires, so software need not read the status words at all. Message signalling and the host transport sit outside the block.

Top module: `ring_irq_ctrl`

## Requirements
- R1: Word address 0x00 reads back the hop count parameter in bits 9:0, with zero above. Writes to it are ignored.
- R2: Pending bits form one flat space. Transmit done of hop h is bit h, receive done is bit HOPS+h, and receive overflow is bit 2*HOPS+h. Flat bit k is read at word address 0x08+k/32, bit k%32.
- R3: A read of a status word returns its pending bits on regRdata one cycle after regRd, and clears those bits. A second read with no new events returns zero.
- R4: An event that arrives in the same cycle as a clearing read of its word stays pending and is returned by the next read.
- R5: The enable index of transmit ring h is h, and that of receive ring h is HOPS+h. Enable index i sits at word address 0x10+i/32, bit i%32, and can be read and written. A ring whose enable bit is zero raises no interrupt.
- R6: Ring index i has a 4-bit vector field at word address 0x18+i/8, bits 4*(i%8)+3 down to 4*(i%8). irqOut[v] pulses only for enabled rings with a pending done bit whose field equals v. Overflow bits never raise an interrupt.
- R7: Word address 0x01 bit 0 is the auto-clear control, read/write.
- R8: The throttle value of vector v is at word address 0x20+v, bits 15:0, in units of TICK_CYCLES clocks. Consecutive pulses on irqOut[v] are exactly max(value*TICK_CYCLES,1) cycles apart while a request persists, and never closer.
- R9: With auto-clear set, a pulse clears the done bits of the enabled rings mapped to that vector, so one event gives one pulse and the status read then returns zero. With auto-clear off the bit stays pending and the vector keeps firing at the throttle interval.
- R10: After reset, all pending, enable, vector-field, throttle and auto-clear state is zero, and irqOut is zero.
- R11: An event on a disabled ring is still recorded. Enabling the ring afterwards produces the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txDone | input | HOPS | Transmit-done strobes, one per hop |
| rxDone | input | HOPS | Receive-done strobes, one per hop |
| rxOvf | input | HOPS | Receive-overflow strobes, one per hop |
| regAddr | input | 8 | Register word address |
| regWr | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRd | input | 1 | Read strobe; status words clear on it |
| regRdata | output | 32 | Read data, valid the cycle after regRd |
| irqOut | output | VECS | One-cycle interrupt pulse per vector |

## Verification
The assertions assume that the event strobes and the register port are quiet during reset. They also assume that a throttle register is not rewritten while its vector has a request outstanding, because the spacing check compares against the value held at the previous pulse. The bench drives every input on the falling edge. It releases reset with all strobes low, and changes throttle values only after the rings are disabled and the status has been drained. Status words are read only at addresses that hold pending bits.

// File: rtl/ringirq_pkg.sv
package ringirq_pkg;
  localparam int ADDR_W  = 8;
  localparam int REG_W   = 32;
  localparam int VF_W    = 4;
  localparam int VF_PER_WORD = REG_W / VF_W;
  localparam int THR_W   = 16;

  localparam int A_HOPCNT = 'h00;
  localparam int A_MISC   = 'h01;
  localparam int A_STAT   = 'h08;
  localparam int A_EN     = 'h10;
  localparam int A_ALLOC  = 'h18;
  localparam int A_THR    = 'h20;

  typedef struct packed {
    logic       statRd;
    logic [2:0] statWord;
  } statStrobe_t;
endpackage

// File: rtl/ringirq_regs.sv
module ringirq_regs
  import ringirq_pkg::*;
#(
  parameter int HOPS = 12,
  parameter int VECS = 4,
  localparam int RINGS = 2 * HOPS,
  localparam int PEND_W = 3 * HOPS,
  localparam int STAT_WORDS = (PEND_W + REG_W - 1) / REG_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           regAddr,
  input  logic                        regWr,
  input  logic [REG_W-1:0]            regWdata,
  input  logic                        regRd,
  output logic [REG_W-1:0]            regRdata,
  input  logic [PEND_W-1:0]           pendFlat,
  output logic [RINGS-1:0]            enFlat,
  output logic [RINGS-1:0][VF_W-1:0]  allocTab,
  output logic [VECS-1:0][THR_W-1:0]  thrTab,
  output logic                        autoClr,
  output statStrobe_t                 strobe
);
  logic [REG_W-1:0] rdNext;
  int               addrI;

  assign addrI = int'(regAddr);

  always_comb begin
    strobe.statRd   = regRd && (addrI >= A_STAT) && (addrI < A_STAT + STAT_WORDS);
    strobe.statWord = regAddr[2:0];
  end

  always_comb begin
    rdNext = '0;
    if (addrI == A_HOPCNT) rdNext[9:0] = 10'(HOPS);
    if (addrI == A_MISC) rdNext[0] = autoClr;
    for (int k = 0; k < PEND_W; k++)
      if (addrI == A_STAT + k / REG_W) rdNext[k % REG_W] = pendFlat[k];
    for (int i = 0; i < RINGS; i++)
      if (addrI == A_EN + i / REG_W) rdNext[i % REG_W] = enFlat[i];
    for (int r = 0; r < RINGS; r++)
      if (addrI == A_ALLOC + r / VF_PER_WORD)
        rdNext[VF_W*(r % VF_PER_WORD) +: VF_W] = allocTab[r];
    for (int v = 0; v < VECS; v++)
      if (addrI == A_THR + v) rdNext[THR_W-1:0] = thrTab[v];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regRdata <= '0;
      autoClr  <= 1'b0;
      enFlat   <= '0;
      allocTab <= '0;
      thrTab   <= '0;
    end else begin
      if (regRd) regRdata <= rdNext;
      if (regWr) begin
        if (addrI == A_MISC) autoClr <= regWdata[0];
        for (int i = 0; i < RINGS; i++)
          if (addrI == A_EN + i / REG_W) enFlat[i] <= regWdata[i % REG_W];
        for (int r = 0; r < RINGS; r++)
          if (addrI == A_ALLOC + r / VF_PER_WORD)
            allocTab[r] <= regWdata[VF_W*(r % VF_PER_WORD) +: VF_W];
        for (int v = 0; v < VECS; v++)
          if (addrI == A_THR + v) thrTab[v] <= regWdata[THR_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ringirq_dp.sv
module ringirq_dp
  import ringirq_pkg::*;
#(
  parameter int HOPS = 12,
  parameter int VECS = 4,
  parameter int TICK_CYCLES = 64,
  localparam int RINGS = 2 * HOPS,
  localparam int PEND_W = 3 * HOPS,
  localparam int CNT_W = THR_W + $clog2(TICK_CYCLES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [HOPS-1:0]             txDone,
  input  logic [HOPS-1:0]             rxDone,
  input  logic [HOPS-1:0]             rxOvf,
  input  statStrobe_t                 strobe,
  input  logic [RINGS-1:0]            enFlat,
  input  logic [RINGS-1:0][VF_W-1:0]  allocTab,
  input  logic [VECS-1:0][THR_W-1:0]  thrTab,
  input  logic                        autoClr,
  output logic [PEND_W-1:0]           pendFlat,
  output logic [VECS-1:0]             irqOut
);
  logic [PEND_W-1:0] evFlat;
  logic [PEND_W-1:0] rdClr;
  logic [RINGS-1:0]  autoMask;
  logic [VECS-1:0]   req;
  logic [VECS-1:0]   fire;
  logic [CNT_W-1:0]  gapCnt [VECS];

  assign evFlat = {rxOvf, rxDone, txDone};

  always_comb begin
    for (int k = 0; k < PEND_W; k++)
      rdClr[k] = strobe.statRd && (int'(strobe.statWord) == k / REG_W);
  end

  always_comb begin
    req = '0;
    for (int r = 0; r < RINGS; r++)
      for (int v = 0; v < VECS; v++)
        if (enFlat[r] && pendFlat[r] && int'(allocTab[r]) == v) req[v] = 1'b1;
  end

  generate
    for (genvar v = 0; v < VECS; v++) begin : g_vec
      assign fire[v] = req[v] && (gapCnt[v] <= CNT_W'(1));
      always_ff @(posedge clk) begin
        if (rst) begin
          gapCnt[v] <= '0;
          irqOut[v] <= 1'b0;
        end else begin
          irqOut[v] <= fire[v];
          if (fire[v])
            gapCnt[v] <= CNT_W'(thrTab[v]) * CNT_W'(TICK_CYCLES);
          else if (gapCnt[v] != '0)
            gapCnt[v] <= gapCnt[v] - 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    autoMask = '0;
    for (int r = 0; r < RINGS; r++)
      for (int v = 0; v < VECS; v++)
        if (autoClr && enFlat[r] && int'(allocTab[r]) == v && fire[v]) autoMask[r] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) pendFlat <= '0;
    else     pendFlat <= (pendFlat & ~(rdClr | {{HOPS{1'b0}}, autoMask})) | evFlat;
  end
endmodule

// File: rtl/ring_irq_ctrl.sv
module ring_irq_ctrl
  import ringirq_pkg::*;
#(
  parameter int HOPS = 12,
  parameter int VECS = 4,
  parameter int TICK_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [HOPS-1:0]   txDone,
  input  logic [HOPS-1:0]   rxDone,
  input  logic [HOPS-1:0]   rxOvf,
  input  logic [7:0]        regAddr,
  input  logic              regWr,
  input  logic [31:0]       regWdata,
  input  logic              regRd,
  output logic [31:0]       regRdata,
  output logic [VECS-1:0]   irqOut
);
  localparam int RINGS  = 2 * HOPS;
  localparam int PEND_W = 3 * HOPS;

  logic [PEND_W-1:0]          pendFlat;
  logic [RINGS-1:0]           enFlat;
  logic [RINGS-1:0][VF_W-1:0] allocTab;
  logic [VECS-1:0][THR_W-1:0] thrTab;
  logic                       autoClr;
  statStrobe_t                strobe;

  ringirq_regs #(.HOPS(HOPS), .VECS(VECS)) u_regs (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata),
    .regRd(regRd), .regRdata(regRdata), .pendFlat(pendFlat), .enFlat(enFlat),
    .allocTab(allocTab), .thrTab(thrTab), .autoClr(autoClr), .strobe(strobe)
  );

  ringirq_dp #(.HOPS(HOPS), .VECS(VECS), .TICK_CYCLES(TICK_CYCLES)) u_dp (
    .clk(clk), .rst(rst), .txDone(txDone), .rxDone(rxDone), .rxOvf(rxOvf),
    .strobe(strobe), .enFlat(enFlat), .allocTab(allocTab), .thrTab(thrTab),
    .autoClr(autoClr), .pendFlat(pendFlat), .irqOut(irqOut)
  );
endmodule

// File: rtl/ringirq_chk.sv
module ringirq_chk #(
  parameter int HOPS = 12,
  parameter int VECS = 4,
  parameter int TICK_CYCLES = 64
) (
  input logic                  clk,
  input logic                  rst,
  input logic [HOPS-1:0]       txDone,
  input logic [HOPS-1:0]       rxDone,
  input logic [HOPS-1:0]       rxOvf,
  input logic [7:0]            regAddr,
  input logic                  regRd,
  input logic [31:0]           regRdata,
  input logic [3*HOPS-1:0]     pendFlat,
  input logic [2*HOPS-1:0]     enFlat,
  input logic [VECS-1:0][15:0] thrTab,
  input logic [VECS-1:0]       irqOut
);
  logic [3*HOPS-1:0] evFlat;
  assign evFlat = {rxOvf, rxDone, txDone};

  p_hopcount_r1: assert property (@(posedge clk) disable iff (rst)
    $past(regRd && regAddr == 8'h00 && !rst) |-> regRdata == 32'(HOPS));

  p_event_kept_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((pendFlat & $past(evFlat)) == $past(evFlat)));

  p_irq_source_r6: assert property (@(posedge clk) disable iff (rst)
    (|irqOut && !$past(rst)) |-> $past(|(pendFlat[2*HOPS-1:0] & enFlat)));

  generate
    for (genvar v = 0; v < VECS; v++) begin : g_gap
      int   gap;
      int   lim;
      logic armed;
      always_ff @(posedge clk) begin
        if (rst) begin
          gap <= 0; lim <= 1; armed <= 1'b0;
        end else if (irqOut[v]) begin
          gap <= 1; armed <= 1'b1;
          lim <= (int'($past(thrTab[v])) * TICK_CYCLES > 1) ? int'($past(thrTab[v])) * TICK_CYCLES : 1;
        end else if (gap < 32'h3fff_ffff) begin
          gap <= gap + 1;
        end
      end
      p_throttle_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (irqOut[v] && armed) |-> gap >= lim);
    end
  endgenerate
endmodule

bind ring_irq_ctrl ringirq_chk #(.HOPS(HOPS), .VECS(VECS), .TICK_CYCLES(TICK_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .txDone(txDone), .rxDone(rxDone), .rxOvf(rxOvf),
  .regAddr(regAddr), .regRd(regRd), .regRdata(regRdata), .pendFlat(pendFlat),
  .enFlat(enFlat), .thrTab(thrTab), .irqOut(irqOut)
);

// File: tb/ring_irq_ctrl_tb.sv
module ring_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOPS = 12;
  localparam int VECS = 4;
  localparam int TICK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [HOPS-1:0] txDone = '0, rxDone = '0, rxOvf = '0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [VECS-1:0] irqOut;

  int checks = 0, fails = 0, cyc = 0;
  int pulses [VECS];
  int lastT  [VECS];
  int minGap [VECS];

  ring_irq_ctrl #(.HOPS(HOPS), .VECS(VECS), .TICK_CYCLES(TICK)) u_dut (
    .clk(clk), .rst(rst), .txDone(txDone), .rxDone(rxDone), .rxOvf(rxOvf),
    .regAddr(regAddr), .regWr(regWr), .regWdata(regWdata), .regRd(regRd),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int v = 0; v < VECS; v++)
      if (irqOut[v]) begin
        pulses[v] = pulses[v] + 1;
        if (lastT[v] >= 0 && cyc - lastT[v] < minGap[v]) minGap[v] = cyc - lastT[v];
        lastT[v] = cyc;
      end
  end

  task automatic clearMon();
    for (int v = 0; v < VECS; v++) begin
      pulses[v] = 0; lastT[v] = -1; minGap[v] = 1 << 30;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWdata = d; regWr = 1'b1;
    @(negedge clk); regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); regAddr = a; regRd = 1'b1;
    @(negedge clk); regRd = 1'b0; d = regRdata;
  endtask

  task automatic ev(input int kind, input int hop);
    @(negedge clk);
    case (kind)
      0: txDone[hop] = 1'b1;
      1: rxDone[hop] = 1'b1;
      default: rxOvf[hop] = 1'b1;
    endcase
    @(negedge clk); txDone = '0; rxDone = '0; rxOvf = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(8'h00, d); check("R1 hop count", d, HOPS);
    wr(8'h00, 32'hffff_ffff);
    rd(8'h00, d); check("R1 hop count write ignored", d, HOPS);
    rd(8'h08, d); check("R10 status0 reset", d, 0);
    rd(8'h10, d); check("R10 enable reset", d, 0);
    rd(8'h01, d); check("R10 autoclear reset", d, 0);
    rd(8'h19, d); check("R10 vector field reset", d, 0);
    rd(8'h22, d); check("R10 throttle reset", d, 0);
    check("R10 no irq after reset", pulses[0] + pulses[1] + pulses[2] + pulses[3], 0);
  endtask

  task automatic t_layout();
    logic [31:0] d;
    clearMon();
    ev(0, 3); ev(1, 5); ev(1, 11); ev(2, 7); ev(2, 10);
    rd(8'h08, d);
    check("R2 status word0 layout", d, (1 << 3) | (1 << 17) | (1 << 23) | (1 << 31));
    rd(8'h09, d); check("R2 status word1 layout", d, 1 << 2);
    rd(8'h08, d); check("R3 word0 cleared by read", d, 0);
    rd(8'h09, d); check("R3 word1 cleared by read", d, 0);
    check("R5 disabled rings no irq", pulses[0] + pulses[1] + pulses[2] + pulses[3], 0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    @(negedge clk); regAddr = 8'h08; regRd = 1'b1; txDone[2] = 1'b1;
    @(negedge clk); regRd = 1'b0; txDone = '0; d = regRdata;
    check("R4 read before event", d, 0);
    rd(8'h08, d); check("R4 event kept across clearing read", d, 1 << 2);
  endtask

  task automatic t_enable_map();
    logic [31:0] d;
    wr(8'h01, 32'h1);
    rd(8'h01, d); check("R7 autoclear readback", d, 1);
    wr(8'h18, 32'h0000_0020);
    wr(8'h1A, 32'h0000_0003);
    rd(8'h1A, d); check("R6 vector field readback", d, 3);
    clearMon();
    ev(0, 1); idle(10);
    check("R11 disabled ring no pulse", pulses[2], 0);
    wr(8'h10, 32'h0001_0002);
    rd(8'h10, d); check("R5 enable readback", d, 32'h0001_0002);
    idle(10);
    check("R11 pulse after late enable", pulses[2], 1);
    check("R6 other vectors quiet", pulses[0] + pulses[1] + pulses[3], 0);
    rd(8'h08, d); check("R9 autoclear drained status", d, 0);
    clearMon();
    ev(1, 4); idle(10);
    check("R6 rx ring 4 routes to vector 3", pulses[3], 1);
    check("R9 single pulse per event", pulses[2], 0);
    clearMon();
    ev(2, 4); idle(10);
    check("R6 overflow raises no irq", pulses[0] + pulses[1] + pulses[2] + pulses[3], 0);
    rd(8'h08, d); check("R2 overflow bit pending", d, 1 << 28);
    wr(8'h10, 32'h0);
    clearMon();
    ev(0, 1); idle(10);
    check("R5 zero enable blocks irq", pulses[2], 0);
    rd(8'h08, d);
  endtask

  task automatic t_throttle();
    logic [31:0] d;
    wr(8'h01, 32'h0);
    wr(8'h22, 32'd3);
    rd(8'h22, d); check("R8 throttle readback", d, 3);
    clearMon();
    wr(8'h10, 32'h0000_0002);
    ev(0, 1); idle(100);
    wr(8'h10, 32'h0); idle(3);
    check("R8 min gap equals value*tick", minGap[2], 3 * TICK);
    check("R9 repeated pulses without autoclear", (pulses[2] >= 7) ? 1 : 0, 1);
    rd(8'h08, d); check("R9 bit still pending without autoclear", d, 1 << 1);
  endtask

  initial begin
    clearMon();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    fork
      begin
        t_reset();
        t_layout();
        t_same_cycle();
        t_enable_map();
        t_throttle();
      end
      begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule